// File: doc/BRIEF.md
# Column Scan Pointer with Window Control

This block drives the column select lines of an image sensor's line readout. It holds a one-hot select vector, so at any moment at most one pixel column (and the sampling stage beneath it) is addressed. During a line the selected column moves from the lowest index (leftmost) towards the highest index, one column per pixel.

The block runs from a fast clock at twice the pixel rate, so every pixel takes two clock cycles. In the first phase a pixel-valid strobe is raised for the column being read. In the second phase the pointer moves on. A start-column register is written over the configuration bus. A load command presets the pointer to that column and captures a window length, which allows region-of-interest readout. When the window has been covered, or when the pointer runs off the highest column, end-of-line rises and the pointer stops until the next load.

Top module: `col_scan_top`

## Requirements
- R1: While reset is high and on the first cycle after it, col_sel is all zero and pix_valid and eol are low.
- R2: A cycle with start_we high stores start_data in the start register. A load presets col_sel to the one-hot vector with bit index equal to the stored value. Bit i selects column i, and column 0 is leftmost. A write in the same cycle as a load is used only by later loads. A stored value of COLS or more presets all zero.
- R3: col_sel never has more than one bit set.
- R4: While running with run high, pix_valid is high for exactly one cycle out of every two, starting one cycle after the first run cycle. While it is high, col_sel points at the pixel being read.
- R5: One cycle after a pix_valid cycle in which run is high and load is low, col_sel has moved to the next higher bit index.
- R6: With run and load low, col_sel and eol hold their values and pix_valid is low in the next cycle. The pixel phase is kept, so the line resumes where it stopped.
- R7: After win_len pixels have been strobed, eol rises on the same edge as the final move and stays high until the next load. Afterwards pix_valid stays low and col_sel does not change.
- R8: A load with win_len equal to zero raises eol one cycle later, and no pixel is strobed.
- R9: Moving on from column COLS-1 leaves col_sel all zero, with no wrap to column 0, and raises eol.
- R10: A load takes priority over run. In the next cycle col_sel holds the preset, pix_valid and eol are low (unless R8 applies), and the pixel phase restarts at the strobe phase.
- R11: After reset and before the first load, run has no effect: col_sel stays all zero and pix_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| start_we | input | 1 | Write strobe for the start-column register |
| start_data | input | ADDR_W | Start column value to store |
| load | input | 1 | Preset the pointer and capture the window length |
| run | input | 1 | Allow the scan to advance |
| win_len | input | LEN_W | Number of pixels in the window, captured on load |
| col_sel | output | COLS | One-hot column select, bit i is column i |
| pix_valid | output | 1 | High during the strobe phase of each pixel |
| eol | output | 1 | End of line: window covered or right edge passed |

## Verification
The bench builds the block with COLS = 12, which gives ADDR_W = 4 and LEN_W = 4. A window started near the right side can therefore run past column 11 well before its length is used up, which exercises the edge stop. The 4-bit start field can also hold values 12 to 15, which are out of range. Twelve columns keep each line to a few dozen cycles, so mid-line pauses, reloads during a running line and zero-length windows all fit into a short run. A behavioural model tracks every cycle against them.

// File: rtl/cps_pkg.sv
package cps_pkg;

  // Two clock phases make up one pixel period.
  typedef enum logic {
    PH_STROBE = 1'b0,
    PH_MOVE   = 1'b1
  } pix_phase_e;

endpackage

// File: rtl/cps_start_reg.sv
module cps_start_reg #(
  parameter int COLS   = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [COLS-1:0]   preset_vec
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (we) begin
      addr_q <= wdata;
    end
  end

  // Decode the stored column to a one-hot vector; out-of-range values give zero.
  for (genvar i = 0; i < COLS; i++) begin : g_dec
    assign preset_vec[i] = (addr_q == ADDR_W'(i));
  end

endmodule

// File: rtl/cps_phase.sv
module cps_phase
  import cps_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic go,
  output logic strobe,
  output logic move
);

  pix_phase_e ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_STROBE;
    end else if (restart) begin
      ph_q <= PH_STROBE;
    end else if (go) begin
      ph_q <= (ph_q == PH_STROBE) ? PH_MOVE : PH_STROBE;
    end
  end

  assign strobe = go && (ph_q == PH_STROBE);
  assign move   = go && (ph_q == PH_MOVE);

endmodule

// File: rtl/cps_window.sv
module cps_window #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             move,
  input  logic             edge_hit,
  output logic             armed,
  output logic             done
);

  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      armed <= 1'b0;
      done  <= 1'b0;
    end else if (load) begin
      rem_q <= len;
      armed <= 1'b1;
      done  <= (len == '0);
    end else if (move) begin
      rem_q <= rem_q - LEN_W'(1);
      if ((rem_q == LEN_W'(1)) || edge_hit) begin
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cps_shift.sv
module cps_shift #(
  parameter int COLS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [COLS-1:0] preset_vec,
  input  logic            move,
  output logic [COLS-1:0] sel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (load) begin
      sel <= preset_vec;
    end else if (move) begin
      // Toward higher index; the top bit falls off, no wrap.
      sel <= {sel[COLS-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/col_scan_top.sv
module col_scan_top #(
  parameter int COLS   = 16,
  parameter int ADDR_W = $clog2(COLS),
  parameter int LEN_W  = $clog2(COLS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_data,
  input  logic              load,
  input  logic              run,
  input  logic [LEN_W-1:0]  win_len,
  output logic [COLS-1:0]   col_sel,
  output logic              pix_valid,
  output logic              eol
);

  localparam int LAST_COL = COLS - 1;

  logic [COLS-1:0] preset_vec;
  logic            armed;
  logic            done;
  logic            go;
  logic            strobe;
  logic            move;
  logic            edge_hit;

  assign go       = run && armed && !done && !load;
  assign edge_hit = col_sel[LAST_COL];

  cps_start_reg #(.COLS(COLS), .ADDR_W(ADDR_W)) u_start (
    .clk        (clk),
    .rst        (rst),
    .we         (start_we),
    .wdata      (start_data),
    .preset_vec (preset_vec)
  );

  cps_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .restart (load),
    .go      (go),
    .strobe  (strobe),
    .move    (move)
  );

  cps_window #(.LEN_W(LEN_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .len      (win_len),
    .move     (move),
    .edge_hit (edge_hit),
    .armed    (armed),
    .done     (done)
  );

  cps_shift #(.COLS(COLS)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .preset_vec (preset_vec),
    .move       (move),
    .sel        (col_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
    end else begin
      pix_valid <= strobe;
    end
  end

  assign eol = done;

endmodule

// File: rtl/cps_chk.sv
module cps_chk #(
  parameter int COLS = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            load,
  input logic            run,
  input logic [COLS-1:0] col_sel,
  input logic            pix_valid,
  input logic            eol
);

  // R3
  onehot_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_sel));

  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> !pix_valid);

  // R5
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && run && !load) |=> (col_sel == ($past(col_sel) << 1)));

  // R6
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> ($stable(col_sel) && $stable(eol) && !pix_valid));

  // R7
  eol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (eol && !load) |=> (eol && $stable(col_sel)));

  // R7
  eol_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    eol |-> !pix_valid);

  // R9
  edge_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && run && !load && col_sel[COLS-1]) |=> ((col_sel == '0) && eol));

  // R10
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !pix_valid);

endmodule

bind col_scan_top cps_chk #(.COLS(COLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .run       (run),
  .col_sel   (col_sel),
  .pix_valid (pix_valid),
  .eol       (eol)
);

// File: tb/col_scan_top_tb.sv
`timescale 1ns/1ps
module col_scan_top_tb;

  localparam int COLS   = 12;
  localparam int ADDR_W = $clog2(COLS);
  localparam int LEN_W  = $clog2(COLS + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_we = 1'b0;
  logic [ADDR_W-1:0] start_data = '0;
  logic              load = 1'b0;
  logic              run = 1'b0;
  logic [LEN_W-1:0]  win_len = '0;
  logic [COLS-1:0]   col_sel;
  logic              pix_valid;
  logic              eol;

  int checks = 0;
  int fails  = 0;
  int pcount = 0;
  int cycles = 0;
  bit seen   = 0;
  bit ended  = 0;

  // reference model state
  int m_start, m_pos, m_ph, m_rem;
  bit m_done, m_armed, m_pv;

  always #10 clk = ~clk;

  col_scan_top #(.COLS(COLS)) u_dut (
    .clk(clk), .rst(rst), .start_we(start_we), .start_data(start_data),
    .load(load), .run(run), .win_len(win_len),
    .col_sel(col_sel), .pix_valid(pix_valid), .eol(eol)
  );

  function automatic logic [COLS-1:0] vec_of(int p);
    logic [COLS-1:0] r = '0;
    if (p >= 0 && p < COLS) r[p] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_start = 0; m_pos = 1000; m_ph = 0; m_rem = 0;
      m_done = 0; m_armed = 0; m_pv = 0;
    end else begin
      if (load) begin
        m_pos = m_start; m_ph = 0; m_rem = int'(win_len);
        m_done = (win_len == 0); m_armed = 1; m_pv = 0;
      end else if (run && m_armed && !m_done) begin
        if (m_ph == 0) begin
          m_pv = 1; m_ph = 1;
        end else begin
          bit hit_edge;
          hit_edge = (m_pos == COLS - 1);
          m_pv = 0; m_ph = 0;
          if (m_pos < 1000) m_pos++;
          m_rem--;
          if (m_rem == 0 || hit_edge) m_done = 1;
        end
      end else begin
        m_pv = 0;
      end
      if (start_we) m_start = int'(start_data);
    end
    seen = 1;
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (seen && !ended) begin
      check("R5", "col_sel vs model", 32'(col_sel), 32'(vec_of(m_pos)));
      check("R4", "pix_valid vs model", 32'(pix_valid), 32'(m_pv));
      check("R7", "eol vs model", 32'(eol), 32'(m_done));
      if (pix_valid === 1'b1) pcount++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_start(int a);
    start_we = 1'b1; start_data = ADDR_W'(a);
    tick(1);
    start_we = 1'b0;
  endtask

  task automatic do_load(int len);
    load = 1'b1; win_len = LEN_W'(len);
    tick(1);
    load = 1'b0;
  endtask

  task automatic run_to_eol();
    run = 1'b1;
    for (int i = 0; i < 80; i++) begin
      if (eol === 1'b1) break;
      tick(1);
    end
  endtask

  task automatic finish_run();
    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000 && !ended) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [COLS-1:0] held;
    tick(3);
    // R1: reset state
    check("R1", "col_sel in reset", 32'(col_sel), 32'h0);
    check("R1", "pix_valid in reset", 32'(pix_valid), 32'h0);
    check("R1", "eol in reset", 32'(eol), 32'h0);
    rst = 1'b0;
    tick(1);
    check("R1", "eol after reset", 32'(eol), 32'h0);

    // R11: run before any load
    run = 1'b1; pcount = 0;
    tick(6);
    check("R11", "col_sel before load", 32'(col_sel), 32'h0);
    check("R11", "no strobes before load", 32'(pcount), 32'h0);
    run = 1'b0;

    // R2 and R7: window of four from column 3
    write_start(3);
    do_load(4);
    check("R2", "preset col 3", 32'(col_sel), 32'(vec_of(3)));
    check("R10", "eol cleared by load", 32'(eol), 32'h0);
    pcount = 0;
    run_to_eol();
    check("R7", "pixels in window", 32'(pcount), 32'd4);
    check("R7", "pointer after window", 32'(col_sel), 32'(vec_of(7)));
    pcount = 0;
    tick(6);
    check("R7", "eol held", 32'(eol), 32'h1);
    check("R7", "no strobes after eol", 32'(pcount), 32'h0);
    check("R7", "pointer held", 32'(col_sel), 32'(vec_of(7)));
    run = 1'b0;

    // R2: write in the same cycle as load uses the old value
    start_we = 1'b1; start_data = ADDR_W'(7);
    do_load(5);
    start_we = 1'b0;
    check("R2", "same-cycle write ignored", 32'(col_sel), 32'(vec_of(3)));
    do_load(5);
    check("R2", "new start on later load", 32'(col_sel), 32'(vec_of(7)));

    // R6: pause mid-line
    write_start(2);
    do_load(5);
    run = 1'b1;
    tick(3);
    run = 1'b0;
    tick(1);
    held = col_sel;
    pcount = 0;
    tick(4);
    check("R6", "pointer frozen", 32'(col_sel), 32'(held));
    check("R6", "no strobes while paused", 32'(pcount), 32'h0);
    pcount = 0;
    run_to_eol();
    check("R6", "line resumes to end", 32'(col_sel), 32'(vec_of(7)));

    // R10: reload during a running line
    write_start(1);
    do_load(6);
    run = 1'b1;
    tick(5);
    write_start(5);
    load = 1'b1; win_len = LEN_W'(2);
    tick(1);
    load = 1'b0;
    check("R10", "reload preset", 32'(col_sel), 32'(vec_of(5)));
    check("R10", "no strobe after reload", 32'(pix_valid), 32'h0);
    pcount = 0;
    run_to_eol();
    check("R10", "reloaded window length", 32'(pcount), 32'd2);

    // R8: zero-length window
    run = 1'b0;
    do_load(0);
    check("R8", "eol at once", 32'(eol), 32'h1);
    pcount = 0;
    run = 1'b1;
    tick(6);
    check("R8", "no strobes", 32'(pcount), 32'h0);
    run = 1'b0;

    // R9: run off the right edge
    write_start(9);
    do_load(8);
    pcount = 0;
    run_to_eol();
    check("R9", "pixels up to edge", 32'(pcount), 32'd3);
    check("R9", "select zero past edge", 32'(col_sel), 32'h0);
    check("R9", "eol at edge", 32'(eol), 32'h1);
    run = 1'b0;

    // R2: out-of-range start presets zero
    write_start(14);
    do_load(2);
    check("R2", "out of range preset", 32'(col_sel), 32'h0);
    run_to_eol();
    run = 1'b0;
    check("R3", "select at most one-hot", 32'($countones(col_sel) <= 1), 32'h1);

    // R1: reset again mid-activity
    write_start(4);
    do_load(6);
    run = 1'b1;
    tick(3);
    rst = 1'b1;
    tick(2);
    check("R1", "select cleared by reset", 32'(col_sel), 32'h0);
    rst = 1'b0;
    run = 1'b0;
    tick(2);
    finish_run();
  end

endmodule